// File: doc/BRIEF.md
# DDR2 Command Spacing Monitor

This block watches an already decoded DDR2 command stream for a single rank and reports every command that arrives before the minimum spacing allowed by the memory. It models which banks hold an open row. It keeps one small down-counter for each timing rule that still has to run out. Each bank has its own counters for the rules tied to that bank. The rank as a whole has counters for the rules shared by all banks. A separate window tracker enforces the rolling limit on how many activates may occur.

Every timing is a parameter counted in clock cycles. The write-side rules are measured from the end of the write data burst, which lies write latency plus half the burst length after the WRITE command. Write latency is additive latency plus CAS latency minus one. A command that breaks a rule is still applied to the bank model, so one early command does not trigger a chain of false reports. Each command yields at most one reason code: the lowest-numbered rule that it breaks.

Top module: `ddr2_cmd_timing_chk`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `viol_o` is 0, `viol_code_o` is 0 and `bank_open_o` is all zero.
- R2: The command encoding is LMR=0, REF=1, PRE=2, PREA=3, ACT=4, WR=5 and RD=6. ACT sets bit `bank_i` of `bank_open_o`, PRE clears that bit, and PREA clears every bit. The result of a command shows on `viol_o`/`viol_code_o` one cycle after the command is sampled, and `viol_o` is 1 exactly when the code is nonzero.
- R3: RD or WR to a closed bank reports code 4. ACT to a bank that is already open reports code 5.
- R4: ACT after ACT on the same bank, closer than T_RC, reports code 6. ACT after that bank was closed by PRE, closer than T_RP, reports code 7. After a close by PREA the limit is T_RP+1, also code 7.
- R5: ACT closer than T_RRD after any earlier ACT reports code 8.
- R6: An ACT that would be the fifth (FAW_ACTS+1) activate inside T_FAW cycles reports code 9.
- R7: RD or WR closer than T_RCD after ACT to the same bank reports code 10. A column command closer than T_CCD after any column command reports code 11.
- R8: RD closer than WL+BL/2+T_WTR after any WR reports code 12.
- R9: PRE or PREA on an open bank reports code 13 inside T_RAS of its ACT, code 14 inside AL+BL/2−2+T_RTP of a RD to it, and code 15 inside WL+BL/2+T_WR of a WR to it.
- R10: ACT or REF closer than T_RFC after REF reports code 3.
- R11: Any command closer than T_MRD after LMR reports code 1. REF or LMR while any bank is open reports code 2.
- R12: When a command breaks several rules, the smallest nonzero code is reported.
- R13: A violating command still updates the bank state and restarts the timers it would normally start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_i | input | 3 | Decoded command type (encoding in R2) |
| bank_i | input | $clog2(NUM_BANKS) | Target bank of ACT, PRE, RD and WR |
| viol_o | output | 1 | Spacing violation pulse for the previous command |
| viol_code_o | output | 4 | Reason code for the violation, 0 when none |
| bank_open_o | output | NUM_BANKS | Open-row flag for each bank |

## Verification
The embedded properties check the local invariants on every cycle. Any armed timer reads busy on the next cycle. ACT opens the addressed bank, PRE closes it and PREA clears every bank. A column access to a closed bank, and REF or LMR issued while a row is open, is always flagged. Which code wins at each spacing boundary cannot be shown by those properties, so directed sequences cover it. Each rule is exercised once one cycle too early and once exactly on time. The sequences also cover the priority between overlapping rules and the way a violating command still reshapes later checks.

// File: rtl/ddr2_tc_pkg.sv
package ddr2_tc_pkg;

   typedef enum logic [2:0] {
      CMD_LMR  = 3'd0,
      CMD_REF  = 3'd1,
      CMD_PRE  = 3'd2,
      CMD_PREA = 3'd3,
      CMD_ACT  = 3'd4,
      CMD_WR   = 3'd5,
      CMD_RD   = 3'd6
   } ddr2_cmd_e;

   // lower value wins when several rules fail at once
   typedef enum logic [3:0] {
      VC_NONE     = 4'd0,
      VC_MRD      = 4'd1,
      VC_NOT_IDLE = 4'd2,
      VC_RFC      = 4'd3,
      VC_CLOSED   = 4'd4,
      VC_OPEN     = 4'd5,
      VC_RC       = 4'd6,
      VC_RP       = 4'd7,
      VC_RRD      = 4'd8,
      VC_FAW      = 4'd9,
      VC_RCD      = 4'd10,
      VC_CCD      = 4'd11,
      VC_WTR      = 4'd12,
      VC_RAS      = 4'd13,
      VC_RTP      = 4'd14,
      VC_WR       = 4'd15
   } tc_code_e;

endpackage

// File: rtl/ddr2_tc_gap.sv
module ddr2_tc_gap #(
   parameter int CW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [CW-1:0] val_i,
   output logic          busy_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (load_i)          cnt_q <= val_i;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   // R13
   gap_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && (val_i != '0)) |=> busy_o);

endmodule

// File: rtl/ddr2_tc_bank.sv
module ddr2_tc_bank #(
   parameter int CW      = 8,
   parameter int T_RCD   = 5,
   parameter int T_RAS   = 15,
   parameter int T_RC    = 20,
   parameter int T_RP    = 5,
   parameter int RTP_GAP = 3,
   parameter int WR_GAP  = 11
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic act_i,
   input  logic pre_i,
   input  logic prea_i,
   input  logic rd_i,
   input  logic wr_i,
   output logic open_o,
   output logic rcd_busy_o,
   output logic ras_busy_o,
   output logic rc_busy_o,
   output logic rp_busy_o,
   output logic rtp_busy_o,
   output logic wr_busy_o
);

   localparam int NT = 6;
   localparam logic [CW-1:0] V_RCD = CW'(T_RCD - 1);
   localparam logic [CW-1:0] V_RAS = CW'(T_RAS - 1);
   localparam logic [CW-1:0] V_RC  = CW'(T_RC - 1);
   localparam logic [CW-1:0] V_RP  = CW'(T_RP - 1);
   localparam logic [CW-1:0] V_RPA = CW'(T_RP);
   localparam logic [CW-1:0] V_RTP = CW'(RTP_GAP - 1);
   localparam logic [CW-1:0] V_WR  = CW'(WR_GAP - 1);

   logic          open_q;
   logic          closing;
   logic [NT-1:0] tmr_load;
   logic [NT-1:0] tmr_busy;
   logic [CW-1:0] tmr_val [NT];

   assign closing = open_q && (pre_i || prea_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       open_q <= 1'b0;
      else if (act_i)    open_q <= 1'b1;
      else if (closing)  open_q <= 1'b0;
   end

   always_comb begin
      tmr_load = {wr_i, rd_i, closing, act_i, act_i, act_i};
      tmr_val[0] = V_RCD;
      tmr_val[1] = V_RAS;
      tmr_val[2] = V_RC;
      tmr_val[3] = prea_i ? V_RPA : V_RP;
      tmr_val[4] = V_RTP;
      tmr_val[5] = V_WR;
   end

   for (genvar g = 0; g < NT; g++) begin : g_tmr
      ddr2_tc_gap #(.CW(CW)) u_gap (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .load_i (tmr_load[g]),
         .val_i  (tmr_val[g]),
         .busy_o (tmr_busy[g])
      );
   end

   assign open_o     = open_q;
   assign rcd_busy_o = tmr_busy[0];
   assign ras_busy_o = tmr_busy[1];
   assign rc_busy_o  = tmr_busy[2];
   assign rp_busy_o  = tmr_busy[3];
   assign rtp_busy_o = tmr_busy[4];
   assign wr_busy_o  = tmr_busy[5];

   // R2
   bank_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i |=> open_o);

   // R2
   bank_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pre_i && open_o) |=> !open_o);

   if (T_RAS > 1) begin : g_ras_chk
      // R9
      ras_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         act_i |=> (ras_busy_o && open_o));
   end

endmodule

// File: rtl/ddr2_tc_faw.sv
module ddr2_tc_faw #(
   parameter int CW    = 8,
   parameter int LIMIT = 4,
   parameter int T_FAW = 13
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic act_i,
   output logic busy_o
);

   localparam logic [CW-1:0] V_WIN = CW'(T_FAW - 1);

   logic [CW-1:0] slot_q [LIMIT];

   function automatic logic [CW-1:0] dec(input logic [CW-1:0] x);
      return (x == '0) ? '0 : x - 1'b1;
   endfunction

   for (genvar g = 0; g < LIMIT; g++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)       slot_q[g] <= '0;
         else if (act_i) begin
            if (g == 0)     slot_q[g] <= V_WIN;
            else            slot_q[g] <= dec(slot_q[(g == 0) ? 0 : g-1]);
         end
         else               slot_q[g] <= dec(slot_q[g]);
      end
   end

   always_comb begin
      busy_o = 1'b1;
      for (int i = 0; i < LIMIT; i++) begin
         if (slot_q[i] == '0) busy_o = 1'b0;
      end
   end

   // R6
   faw_fresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i |=> (slot_q[0] != '0) || (T_FAW <= 1));

endmodule

// File: rtl/ddr2_cmd_timing_chk.sv
module ddr2_cmd_timing_chk
   import ddr2_tc_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int CAS_LAT   = 5,
   parameter int ADD_LAT   = 0,
   parameter int BURST_LEN = 4,
   parameter int T_RCD     = 5,
   parameter int T_RAS     = 15,
   parameter int T_RC      = 20,
   parameter int T_RRD     = 3,
   parameter int T_FAW     = 13,
   parameter int FAW_ACTS  = 4,
   parameter int T_RP      = 5,
   parameter int T_CCD     = 2,
   parameter int T_MRD     = 2,
   parameter int T_WTR     = 3,
   parameter int T_RTP     = 3,
   parameter int T_WR      = 5,
   parameter int T_RFC     = 43,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 cmd_valid_i,
   input  logic [2:0]           cmd_i,
   input  logic [BA_W-1:0]      bank_i,
   output logic                 viol_o,
   output logic [3:0]           viol_code_o,
   output logic [NUM_BANKS-1:0] bank_open_o
);

   localparam int WLAT    = ADD_LAT + CAS_LAT - 1;
   localparam int WEND    = WLAT + BURST_LEN / 2;
   localparam int WTR_GAP = WEND + T_WTR;
   localparam int WR_GAP  = WEND + T_WR;
   localparam int RTP_GAP = ADD_LAT + BURST_LEN / 2 - 2 + T_RTP;
   localparam int TSUM    = T_RFC + T_RC + T_FAW + WTR_GAP + WR_GAP + RTP_GAP
                            + T_RP + T_MRD + T_CCD + T_RRD;
   localparam int CW      = $clog2(TSUM + 1);
   localparam int NRK     = 5;
   localparam logic [CW-1:0] RK_V [NRK] = '{
      CW'(T_MRD - 1), CW'(T_RFC - 1), CW'(T_RRD - 1),
      CW'(T_CCD - 1), CW'(WTR_GAP - 1)};

   // elaboration-time parameter checks
   if (BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
      $error("burst length must be 4 or 8");
   end
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_nb
      $error("bank count must be a power of two");
   end
   if (T_RCD < 1 || T_RAS < 1 || T_RC < 1 || T_RRD < 1 || T_FAW < 1 ||
       T_RP < 1 || T_CCD < 1 || T_MRD < 1 || T_WTR < 1 || T_RTP < 1 ||
       T_WR < 1 || T_RFC < 1) begin : g_bad_t
      $error("every timing must be at least one cycle");
   end
   if (T_RC < T_RAS) begin : g_bad_rc
      $error("row cycle shorter than row active time");
   end
   if (FAW_ACTS < 1 || CAS_LAT < 2 || ADD_LAT < 0) begin : g_bad_misc
      $error("activate limit or latency out of range");
   end

   ddr2_cmd_e cmd;
   logic is_act, is_pre, is_prea, is_rd, is_wr, is_ref, is_lmr;

   assign cmd     = ddr2_cmd_e'(cmd_i);
   assign is_act  = cmd_valid_i && (cmd == CMD_ACT);
   assign is_pre  = cmd_valid_i && (cmd == CMD_PRE);
   assign is_prea = cmd_valid_i && (cmd == CMD_PREA);
   assign is_rd   = cmd_valid_i && (cmd == CMD_RD);
   assign is_wr   = cmd_valid_i && (cmd == CMD_WR);
   assign is_ref  = cmd_valid_i && (cmd == CMD_REF);
   assign is_lmr  = cmd_valid_i && (cmd == CMD_LMR);

   // per-bank state
   logic [NUM_BANKS-1:0] open_v, rcd_v, ras_v, rc_v, rp_v, rtp_v, wr_v;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = (bank_i == BA_W'(b));
      ddr2_tc_bank #(
         .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
         .RTP_GAP(RTP_GAP), .WR_GAP(WR_GAP)
      ) u_bank (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .act_i      (is_act && hit),
         .pre_i      (is_pre && hit),
         .prea_i     (is_prea),
         .rd_i       (is_rd && hit),
         .wr_i       (is_wr && hit),
         .open_o     (open_v[b]),
         .rcd_busy_o (rcd_v[b]),
         .ras_busy_o (ras_v[b]),
         .rc_busy_o  (rc_v[b]),
         .rp_busy_o  (rp_v[b]),
         .rtp_busy_o (rtp_v[b]),
         .wr_busy_o  (wr_v[b])
      );
   end

   // rank-wide timers: 0 mode load, 1 refresh, 2 act-act, 3 column, 4 write-read
   logic [NRK-1:0] rk_load, rk_busy;
   assign rk_load = {is_wr, is_rd || is_wr, is_act, is_ref, is_lmr};

   for (genvar g = 0; g < NRK; g++) begin : g_rank
      ddr2_tc_gap #(.CW(CW)) u_gap (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .load_i (rk_load[g]),
         .val_i  (RK_V[g]),
         .busy_o (rk_busy[g])
      );
   end

   logic faw_busy;
   ddr2_tc_faw #(.CW(CW), .LIMIT(FAW_ACTS), .T_FAW(T_FAW)) u_faw (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .act_i  (is_act),
      .busy_o (faw_busy)
   );

   // rule evaluation
   logic s_open, s_rcd, s_ras, s_rc, s_rp, s_rtp, s_wr, any_open;
   logic a_ras, a_rtp, a_wr;
   tc_code_e code_d;

   assign s_open   = open_v[bank_i];
   assign s_rcd    = rcd_v[bank_i];
   assign s_ras    = ras_v[bank_i];
   assign s_rc     = rc_v[bank_i];
   assign s_rp     = rp_v[bank_i];
   assign s_rtp    = rtp_v[bank_i];
   assign s_wr     = wr_v[bank_i];
   assign any_open = |open_v;
   assign a_ras    = |(open_v & ras_v);
   assign a_rtp    = |(open_v & rtp_v);
   assign a_wr     = |(open_v & wr_v);

   always_comb begin
      code_d = VC_NONE;
      if (cmd_valid_i && rk_busy[0] &&
          (is_act || is_pre || is_prea || is_rd || is_wr || is_ref || is_lmr)) begin
         code_d = VC_MRD;
      end else if (is_act) begin
         if      (rk_busy[1]) code_d = VC_RFC;
         else if (s_open)     code_d = VC_OPEN;
         else if (s_rc)       code_d = VC_RC;
         else if (s_rp)       code_d = VC_RP;
         else if (rk_busy[2]) code_d = VC_RRD;
         else if (faw_busy)   code_d = VC_FAW;
      end else if (is_rd || is_wr) begin
         if      (!s_open)             code_d = VC_CLOSED;
         else if (s_rcd)               code_d = VC_RCD;
         else if (rk_busy[3])          code_d = VC_CCD;
         else if (is_rd && rk_busy[4]) code_d = VC_WTR;
      end else if (is_pre) begin
         if (s_open) begin
            if      (s_ras) code_d = VC_RAS;
            else if (s_rtp) code_d = VC_RTP;
            else if (s_wr)  code_d = VC_WR;
         end
      end else if (is_prea) begin
         if      (a_ras) code_d = VC_RAS;
         else if (a_rtp) code_d = VC_RTP;
         else if (a_wr)  code_d = VC_WR;
      end else if (is_ref) begin
         if      (any_open)   code_d = VC_NOT_IDLE;
         else if (rk_busy[1]) code_d = VC_RFC;
      end else if (is_lmr) begin
         if (any_open) code_d = VC_NOT_IDLE;
      end
   end

   logic       viol_q;
   logic [3:0] code_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         viol_q <= 1'b0;
         code_q <= '0;
      end else begin
         viol_q <= (code_d != VC_NONE);
         code_q <= code_d;
      end
   end

   assign viol_o      = viol_q;
   assign viol_code_o = code_q;
   assign bank_open_o = open_v;

   // R3
   closed_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((is_rd || is_wr) && !bank_open_o[bank_i]) |=> viol_o);

   // R2
   act_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_act |=> bank_open_o[$past(bank_i)]);

   // R2
   prea_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_prea |=> (bank_open_o == '0));

   // R11
   busy_maint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((is_ref || is_lmr) && (bank_open_o != '0)) |=> viol_o);

endmodule

// File: tb/sim_ddr2_cmd_timing_chk.sv
`timescale 1ns/1ps
module sim_ddr2_cmd_timing_chk;

   localparam int LMR = 0, REF = 1, PRE = 2, PREA = 3, ACT = 4, WR = 5, RD = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd = '0;
   logic [2:0] bank = '0;
   logic       viol;
   logic [3:0] code;
   logic [7:0] open_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   ddr2_cmd_timing_chk u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .cmd_valid_i (cmd_valid),
      .cmd_i       (cmd),
      .bank_i      (bank),
      .viol_o      (viol),
      .viol_code_o (code),
      .bank_open_o (open_b)
   );

   task automatic expect_code(input string req, input int exp);
      checks++;
      if (viol !== (exp != 0) || code !== 4'(exp)) begin
         fails++;
         $display("FAIL %s: viol=%0b code=%0d, expected viol=%0b code=%0d",
                  req, viol, code, (exp != 0), exp);
      end
   endtask

   task automatic expect_open(input string req, input logic [7:0] exp);
      checks++;
      if (open_b !== exp) begin
         fails++;
         $display("FAIL %s: bank_open=%h, expected %h", req, open_b, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cmd_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // drive at a falling edge, sample after the next rising edge
   task automatic issue(input int c, input int b);
      cmd_valid = 1'b1;
      cmd = 3'(c);
      bank = 3'(b);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // command placed k cycles after the previous one
   task automatic step(input int k, input int c, input int b);
      repeat (k - 1) @(negedge clk);
      issue(c, b);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      expect_code("R1 in reset", 0);
      expect_open("R1 in reset", 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      expect_code("R1 after reset", 0);
      expect_open("R1 after reset", 8'h00);
   endtask

   task automatic t_open_close();
      do_reset();
      issue(ACT, 3);          expect_code("R2 act", 0); expect_open("R2 act b3", 8'h08);
      step(15, PRE, 3);       expect_code("R2 pre", 0); expect_open("R2 pre b3", 8'h00);
      step(5, ACT, 1);        expect_open("R2 act b1", 8'h02);
      step(3, ACT, 5);        expect_code("R2 act b5", 0); expect_open("R2 two open", 8'h22);
      step(15, PREA, 0);      expect_code("R2 prea", 0); expect_open("R2 prea", 8'h00);
   endtask

   task automatic t_closed_open();
      do_reset();
      issue(RD, 2);           expect_code("R3 read closed", 4);
      step(2, WR, 6);         expect_code("R3 write closed", 4);
      step(3, ACT, 0);        expect_code("R3 act", 0);
      step(20, ACT, 0);       expect_code("R3 act open bank", 5);
   endtask

   task automatic t_rc_rp();
      do_reset();
      issue(ACT, 2);
      step(14, PRE, 2);       expect_code("R9 ras early", 13);
      step(5, ACT, 2);        expect_code("R4 rc early", 6);
      expect_open("R13 bank reopened", 8'h04);
      do_reset();
      issue(ACT, 2);
      step(16, PRE, 2);       expect_code("R4 pre", 0);
      step(4, ACT, 2);        expect_code("R4 rp early", 7);
      do_reset();
      issue(ACT, 2);
      step(15, PRE, 2);
      step(5, ACT, 2);        expect_code("R4 rp and rc on time", 0);
      do_reset();
      issue(ACT, 1);
      step(15, PREA, 0);      expect_code("R4 prea", 0);
      step(5, ACT, 1);        expect_code("R4 prea rp+1 early", 7);
      do_reset();
      issue(ACT, 1);
      step(15, PREA, 0);
      step(6, ACT, 1);        expect_code("R4 prea rp+1 on time", 0);
   endtask

   task automatic t_rrd();
      do_reset();
      issue(ACT, 0);
      step(2, ACT, 1);        expect_code("R5 rrd early", 8);
      step(3, ACT, 2);        expect_code("R5 rrd on time", 0);
   endtask

   task automatic t_faw(input int last_gap, input int exp);
      do_reset();
      issue(ACT, 0);
      step(3, ACT, 1);
      step(3, ACT, 2);
      step(3, ACT, 3);        expect_code("R6 fourth act", 0);
      step(last_gap, ACT, 4); expect_code("R6 fifth act", exp);
   endtask

   task automatic t_rcd_ccd();
      do_reset();
      issue(ACT, 0);
      step(4, RD, 0);         expect_code("R7 rcd early", 10);
      step(1, RD, 0);         expect_code("R7 ccd early", 11);
      step(2, RD, 0);         expect_code("R7 ccd on time", 0);
      step(2, WR, 0);         expect_code("R7 write after read", 0);
   endtask

   task automatic t_wtr(input int gap, input int exp);
      do_reset();
      issue(ACT, 0);
      step(5, WR, 0);         expect_code("R7 rcd on time", 0);
      step(gap, RD, 0);       expect_code("R8 write to read", exp);
   endtask

   task automatic t_rtp(input int rd_at, input int exp);
      do_reset();
      issue(ACT, 0);
      step(rd_at, RD, 0);
      step(15 - rd_at, PRE, 0); expect_code("R9 read to pre", exp);
   endtask

   task automatic t_wr(input int pre_gap, input int exp);
      do_reset();
      issue(ACT, 0);
      step(5, WR, 0);
      step(pre_gap, PRE, 0);  expect_code("R9 write recovery", exp);
   endtask

   task automatic t_rfc();
      do_reset();
      issue(REF, 0);          expect_code("R10 ref idle", 0);
      step(42, ACT, 0);       expect_code("R10 act early", 3);
      do_reset();
      issue(REF, 0);
      step(42, REF, 0);       expect_code("R10 ref early", 3);
      do_reset();
      issue(REF, 0);
      step(43, ACT, 0);       expect_code("R10 act on time", 0);
   endtask

   task automatic t_mrd();
      do_reset();
      issue(LMR, 0);          expect_code("R11 lmr idle", 0);
      step(1, ACT, 0);        expect_code("R11 mrd early", 1);
      step(5, LMR, 0);        expect_code("R11 lmr with open bank", 2);
      step(2, REF, 0);        expect_code("R11 ref with open bank", 2);
      do_reset();
      issue(LMR, 0);
      step(2, ACT, 0);        expect_code("R11 mrd on time", 0);
   endtask

   task automatic t_priority();
      do_reset();
      issue(ACT, 0);
      step(1, ACT, 0);        expect_code("R12 open beats rc/rrd", 5);
      step(3, LMR, 0);        expect_code("R12 lmr open bank", 2);
      step(1, REF, 0);        expect_code("R12 mrd beats not-idle", 1);
   endtask

   task automatic t_update();
      do_reset();
      issue(ACT, 4);
      step(2, ACT, 5);        expect_code("R13 rrd early", 8);
      expect_open("R13 early act opens", 8'h30);
      step(2, ACT, 6);        expect_code("R13 rrd restarted", 8);
      expect_open("R13 third act opens", 8'h70);
   endtask

   initial begin
      t_reset();
      t_open_close();
      t_closed_open();
      t_rc_rp();
      t_rrd();
      t_faw(3, 9);
      t_faw(4, 0);
      t_rcd_ccd();
      t_wtr(8, 12);
      t_wtr(9, 0);
      t_rtp(13, 14);
      t_rtp(12, 0);
      t_wr(10, 15);
      t_wr(11, 0);
      t_rfc();
      t_mrd();
      t_priority();
      t_update();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule